// File: doc/BRIEF.md
# I2C SCL Baud Divider

This block derives the serial clock timing of an I2C master from a much faster core clock. A 7-bit divider setting, written by the host as one word, holds two fields: a linear factor M and an exponent N. A two-stage prescaler divides the core clock by (M+1)·2^(N+1) and emits a one-cycle sample tick for the bit engine. A phase counter then spends ten sample ticks on every SCL period: five with the line low and five with it high. The SCL frequency is therefore the core clock divided by 10·(M+1)·2^(N+1).

Four quarter-period strobes mark the points where the byte controller acts: the start of the low half, the middle of the low half, the start of the high half and the middle of the high half. Clock stretching and arbitration belong to the byte controller, so this block only reports timing. Writing the divider setting restarts both stages from zero. Dropping the enable input stops the whole chain. The reset value of the setting is computed at elaboration. It is the fastest rate that does not exceed the target SCL rate for the given core clock.

Top module: `i2cbd_divider`

## Requirements
- R1: A write takes N from `cfg_wdata[2:0]` and M from `cfg_wdata[6:3]`; bits 7 and above have no effect on the timing.
- R2: While enabled and not rewritten, successive `sample_tick` pulses are exactly D = (M+1)·2^(N+1) core cycles apart.
- R3: `scl_level` changes only in the cycle after a sample tick (or after a restart or disable). It is low for the first five ticks of each ten-tick period and high for the last five. After the i-th tick since a restart it equals 1 when ((i) mod 10) ≥ 5.
- R4: If `cfg_we` is high in cycle w, `scl_level` is low from cycle w+1 and the first `sample_tick` is high in cycle w+D of the new setting.
- R5: While `enable` is low, no sample tick or strobe is issued and `scl_level` is low from the next cycle on. If `enable` is first high again in cycle x, the first tick is high in cycle x+D−1.
- R6: `quarter_stb` is zero or one-hot and only high together with a tick. For the i-th tick since a restart, bit 0 is set when i mod 10 = 0, bit 1 when it is 3, bit 2 when it is 5 and bit 3 when it is 8.
- R7: Out of reset the setting is M=12, N=2 (for a 100 MHz core and a 100 kHz target), giving D=104. During reset all outputs are low.
- R8: `sample_tick` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the divider chain when high |
| cfg_we | input | 1 | Loads the divider setting and restarts the chain |
| cfg_wdata | input | CFG_W (32) | Setting word: N in [2:0], M in [6:3] |
| sample_tick | output | 1 | One-cycle pulse every D core cycles |
| scl_level | output | 1 | Divided SCL level (low half, then high half) |
| quarter_stb | output | 4 | Quarter-period strobes, one-hot, coincident with a tick |

## Verification
The tick is decoded from the counter state, so it appears in the same cycle the counters reach their last value. That is D cycles after a write cycle and D−1 cycles after the first enabled cycle. The SCL level is decoded from the registered phase count, so it reflects a tick one cycle after that tick. The bench drives at falling edges and counts falling edges from the stimulus, which makes cycle index k equal the cycle w+k. Each check compares the count at which a tick is seen, or the level seen one edge after a tick, against these offsets. The offsets are computed from M and N in the bench.

// File: rtl/i2cbd_pkg.sv
package i2cbd_pkg;

  // Elaboration-time search for the divider fields whose SCL rate is the
  // highest one not above the target. Result packs {m[7:0], n[7:0]}.
  function automatic logic [15:0] pick_fields(input longint core_hz,
                                              input longint target_hz,
                                              input int     ticks,
                                              input int     m_w,
                                              input int     n_w);
    longint     rate;
    longint     best_gap;
    logic [7:0] best_m;
    logic [7:0] best_n;
    best_gap = -1;
    best_m   = 8'((1 << m_w) - 1);
    best_n   = 8'((1 << n_w) - 1);
    for (int n = 0; n < (1 << n_w); n++) begin
      for (int m = 0; m < (1 << m_w); m++) begin
        rate = core_hz / (longint'(ticks) * longint'(m + 1) * (longint'(2) << n));
        if (rate <= target_hz && (best_gap < 0 || (target_hz - rate) < best_gap)) begin
          best_gap = target_hz - rate;
          best_m   = 8'(m);
          best_n   = 8'(n);
        end
      end
    end
    return {best_m, best_n};
  endfunction

endpackage

// File: rtl/i2cbd_cfg_reg.sv
module i2cbd_cfg_reg #(
  parameter int              CFG_W = 32,
  parameter int              M_W   = 4,
  parameter int              N_W   = 3,
  parameter logic [M_W-1:0]  DEF_M = '0,
  parameter logic [N_W-1:0]  DEF_N = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [M_W-1:0]   m_val,
  output logic [N_W-1:0]   n_val,
  output logic             restart
);
  localparam int FIELD_W = M_W + N_W;

  logic cfg_hi_unused;
  assign cfg_hi_unused = ^wr_data[CFG_W-1:FIELD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_val <= DEF_M;
      n_val <= DEF_N;
    end else if (wr_en) begin
      n_val <= wr_data[N_W-1:0];
      m_val <= wr_data[N_W +: M_W];
    end
  end

  // The write itself clears the counters at the same edge that loads
  // the fields, so the new setting counts from zero on the next cycle.
  assign restart = wr_en;
endmodule

// File: rtl/i2cbd_prescaler.sv
module i2cbd_prescaler #(
  parameter int M_W = 4,
  parameter int N_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           clear,
  input  logic [M_W-1:0] m_val,
  input  logic [N_W-1:0] n_val,
  output logic           tick_o
);
  localparam int POW_W = 1 << N_W;

  logic [M_W-1:0]   lin_cnt;
  logic [POW_W-1:0] pow_cnt;
  logic [POW_W-1:0] pow_last;
  logic             lin_wrap;
  logic             pow_wrap;

  // Last value of the power-of-two stage: 2^(N+1) - 1.
  assign pow_last = ~({POW_W{1'b1}} << (int'(n_val) + 1));
  assign lin_wrap = (lin_cnt == m_val);
  assign pow_wrap = (pow_cnt == pow_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_cnt <= '0;
      pow_cnt <= '0;
    end else if (clear || !enable) begin
      lin_cnt <= '0;
      pow_cnt <= '0;
    end else if (lin_wrap) begin
      lin_cnt <= '0;
      pow_cnt <= pow_wrap ? '0 : pow_cnt + 1'b1;
    end else begin
      lin_cnt <= lin_cnt + 1'b1;
    end
  end

  assign tick_o = enable & ~clear & lin_wrap & pow_wrap;
endmodule

// File: rtl/i2cbd_phase_gen.sv
module i2cbd_phase_gen #(
  parameter int TICKS = 10,
  parameter int NQ    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          clear,
  input  logic          tick,
  output logic          scl_o,
  output logic [NQ-1:0] stb_o
);
  localparam int TICK_W    = $clog2(TICKS);
  localparam int LOW_TICKS = TICKS / 2;

  logic [TICK_W-1:0] t_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_cnt <= '0;
    end else if (clear || !enable) begin
      t_cnt <= '0;
    end else if (tick) begin
      t_cnt <= (t_cnt == TICK_W'(TICKS - 1)) ? '0 : t_cnt + 1'b1;
    end
  end

  assign scl_o = (t_cnt >= TICK_W'(LOW_TICKS));

  // Quarter q begins at tick position ceil(q*TICKS/NQ); its strobe rides on
  // the tick that moves the phase count onto that position.
  for (genvar q = 0; q < NQ; q++) begin : g_quarter
    localparam int QPOS = (q * TICKS + NQ - 1) / NQ;
    localparam int PREV = (QPOS + TICKS - 1) % TICKS;
    assign stb_o[q] = tick & (t_cnt == TICK_W'(PREV));
  end
endmodule

// File: rtl/i2cbd_divider.sv
module i2cbd_divider #(
  parameter longint CORE_HZ = 100_000_000,
  parameter longint SCL_HZ  = 100_000,
  parameter int     CFG_W   = 32,
  parameter int     M_W     = 4,
  parameter int     N_W     = 3,
  parameter int     TICKS   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             sample_tick,
  output logic             scl_level,
  output logic [3:0]       quarter_stb
);
  import i2cbd_pkg::*;

  localparam logic [15:0]    DEF_PAIR = pick_fields(CORE_HZ, SCL_HZ, TICKS, M_W, N_W);
  localparam logic [M_W-1:0] DEF_M    = DEF_PAIR[8 +: M_W];
  localparam logic [N_W-1:0] DEF_N    = DEF_PAIR[0 +: N_W];

  logic [M_W-1:0] m_val;
  logic [N_W-1:0] n_val;
  logic           restart;

  i2cbd_cfg_reg #(
    .CFG_W(CFG_W), .M_W(M_W), .N_W(N_W), .DEF_M(DEF_M), .DEF_N(DEF_N)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .m_val(m_val), .n_val(n_val), .restart(restart)
  );

  i2cbd_prescaler #(.M_W(M_W), .N_W(N_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clear(restart),
    .m_val(m_val), .n_val(n_val), .tick_o(sample_tick)
  );

  i2cbd_phase_gen #(.TICKS(TICKS), .NQ(4)) phase_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clear(restart),
    .tick(sample_tick), .scl_o(scl_level), .stb_o(quarter_stb)
  );
endmodule

// File: rtl/i2cbd_divider_chk.sv
module i2cbd_divider_chk #(
  parameter int M_W = 4,
  parameter int N_W = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           enable,
  input logic           cfg_we,
  input logic [M_W-1:0] cfg_m,
  input logic [N_W-1:0] cfg_n,
  input logic           sample_tick,
  input logic           scl_level,
  input logic [3:0]     quarter_stb
);
  logic [31:0] gap_cnt;
  logic        armed;
  logic [31:0] exp_span;

  assign exp_span = (32'(cfg_m) + 32'd1) << (int'(cfg_n) + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      armed   <= 1'b0;
    end else if (cfg_we || !enable) begin
      gap_cnt <= '0;
      armed   <= 1'b0;
    end else if (sample_tick) begin
      gap_cnt <= 32'd1;
      armed   <= 1'b1;
    end else begin
      gap_cnt <= gap_cnt + 32'd1;
    end
  end

  assert_tick_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && armed) |-> (gap_cnt == exp_span));

  assert_scl_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_tick && !cfg_we && enable) |=> $stable(scl_level));

  assert_restart_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!scl_level && !sample_tick));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!sample_tick && quarter_stb == 4'b0));

  assert_idle_scl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_level);

  assert_strobe_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(quarter_stb));

  assert_strobe_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (quarter_stb != 4'b0) |-> sample_tick);

  assert_tick_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);
endmodule

bind i2cbd_divider i2cbd_divider_chk #(.M_W(M_W), .N_W(N_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
  .cfg_m(m_val), .cfg_n(n_val), .sample_tick(sample_tick),
  .scl_level(scl_level), .quarter_stb(quarter_stb)
);

// File: tb/i2cbd_divider_tb_top.sv
module i2cbd_divider_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        sample_tick;
  logic        scl_level;
  logic [3:0]  quarter_stb;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2cbd_divider dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .sample_tick(sample_tick),
    .scl_level(scl_level), .quarter_stb(quarter_stb)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  function automatic int exp_stb(input int i);
    case (i % 10)
      0: return 1;
      3: return 2;
      5: return 4;
      8: return 8;
      default: return 0;
    endcase
  endfunction

  task automatic write_cfg(input logic [31:0] data);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = data;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // Counts falling edges from the current one until a tick is seen.
  task automatic wait_tick(input int start_k, output int k);
    k = start_k;
    while (!sample_tick && k < LIMIT) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic run_config(input int m, input int n, input logic [31:0] hi, input string first_tag);
    int d;
    int k;
    d = (m + 1) << (n + 1);
    write_cfg(hi | 32'((m << 3) | n));
    check(scl_level == 1'b0, "R4 scl low after write", int'(scl_level), 0);
    wait_tick(1, k);
    check(k == d, first_tag, k, d);
    check(int'(quarter_stb) == exp_stb(1), "R6 strobe tick 1", int'(quarter_stb), exp_stb(1));
    check(scl_level == 1'b0, "R3 scl before tick 1", int'(scl_level), 0);
    for (int i = 2; i <= 10; i++) begin
      @(negedge clk);
      if (i == 2) check(sample_tick == 1'b0, "R8 tick width", int'(sample_tick), 0);
      wait_tick(1, k);
      check(k == d, "R2 tick spacing", k, d);
      check(int'(quarter_stb) == exp_stb(i), "R6 quarter strobe", int'(quarter_stb), exp_stb(i));
      check(int'(scl_level) == int'(((i - 1) % 10) >= 5), "R3 scl level", int'(scl_level),
            int'(((i - 1) % 10) >= 5));
    end
    @(negedge clk);
    check(scl_level == 1'b0, "R3 scl wraps low", int'(scl_level), 0);
  endtask

  initial begin
    int k;
    int idle_bad;
    // Reset state, R7
    repeat (3) @(negedge clk);
    check(sample_tick == 1'b0 && scl_level == 1'b0 && quarter_stb == 4'b0,
          "R7 reset outputs", int'({sample_tick, scl_level, quarter_stb}), 0);
    enable = 1'b1;
    rst_n  = 1'b1;
    @(negedge clk);
    wait_tick(1, k);
    @(negedge clk);
    wait_tick(1, k);
    check(k == 104, "R7 default spacing", k, 104);

    // Sweep all M for small N, R2/R3/R4/R6
    for (int n = 0; n <= 2; n++)
      for (int m = 0; m <= 15; m++)
        run_config(m, n, 32'h0, "R4 first tick after write");
    for (int n = 3; n <= 7; n++)
      run_config(0, n, 32'h0, "R4 first tick after write");
    run_config(15, 7, 32'h0, "R4 first tick after write");

    // R1: upper bits of the setting word must not alter the timing
    run_config(2, 1, 32'hFFFF_FF80, "R1 upper bits ignored");
    run_config(0, 0, 32'hA5A5_A580, "R1 upper bits ignored");

    // R5: disable with SCL high, stay quiet, then resume
    write_cfg(32'((1 << 3) | 0));
    for (int i = 1; i <= 7; i++) begin
      @(negedge clk);
      wait_tick(1, k);
    end
    @(negedge clk);
    check(scl_level == 1'b1, "R3 scl high after 7 ticks", int'(scl_level), 1);
    enable = 1'b0;
    @(negedge clk);
    check(scl_level == 1'b0, "R5 scl low when disabled", int'(scl_level), 0);
    idle_bad = 0;
    for (int i = 0; i < 40; i++) begin
      if (sample_tick || scl_level || quarter_stb != 4'b0) idle_bad++;
      @(negedge clk);
    end
    check(idle_bad == 0, "R5 no activity while disabled", idle_bad, 0);
    enable = 1'b1;
    @(negedge clk);
    wait_tick(1, k);
    check(k == 3, "R5 first tick after enable", k, 3);
    check(int'(quarter_stb) == exp_stb(1), "R5 phase restarted", int'(quarter_stb), exp_stb(1));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule